// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller Core

This block gathers 40 level-sensitive interrupt sources into two banks of up to 32 bits each. Bank 0 holds sources 0 to 31 and bank 1 holds sources 32 to 39. Each source has an enable bit and a routing bit. Together they decide whether a pending source reaches the fast interrupt output, the normal interrupt output, or neither. A wake output tells an idle core that something needs attention. The wake output can be made to react to every pending source, even a masked one.

Software reaches the block through a simple 32-bit register port addressed by byte offsets. The port has a write strobe and a combinational read. It can see pending state in three views: filtered for the normal output, filtered for the fast output, and raw. It can also write the enable and routing vectors, the wake-control bit, and a table of 40 priority entries. The priority table is only stored here. A separate resolver picks the winning source, and it receives the enabled pending vector, the routing vector and the whole table from this block's export ports.

Top module: `dual_bank_intc`

## Requirements
- R1: Source n (0..31) appears at bit n of bank 0, and source n (32..39) at bit n-32 of bank 1. Raw pending reads at offset 0x10 for bank 0 and at 0xAC for bank 1. Bank 1 reads return zero in bits 31:8.
- R2: After reset the enable, routing and pending vectors and every priority entry read zero, the control bit reads 1, and fiqOut, irqOut and wakeOut are low.
- R3: Each pending bit copies its srcLevel input at every rising clock edge, with no latching. A source that drops is no longer pending one cycle later.
- R4: A routing bit of 1 selects the fast path. The normal-pending view (0x00, 0x9C) reads raw & enable & ~routing. The fast-pending view (0x0C, 0xA8) reads raw & enable & routing.
- R5: fiqOut is high exactly when some source is pending, enabled and routed fast in either bank. irqOut is high exactly when some source is pending, enabled and routed normal in either bank. Both follow the registered state combinationally.
- R6: Enable registers sit at 0x04 (bank 0) and 0xA0 (bank 1), and routing registers at 0x08 and 0xA4. Each reads back what was last written. A bank 1 write keeps only data bits 7:0.
- R7: wakeOut is high exactly when coreIdle is high and some pending source has either its enable bit set or the control bit at 0.
- R8: The control register at 0x14 stores write-data bit 0. A read returns that bit in bit 0 and zeros elsewhere.
- R9: Priority entry i is at 0x1C+4i for i < 32 and at 0xB0+4(i-32) for i from 32 to 39. A write stores data bits 31 and 5:0 only. A read returns those bits in place, with bits 30:6 zero.
- R10: A read at any other offset returns 0, including 0x18, misaligned offsets and offsets above 0xCC. A write there, or to any pending view, changes no state.
- R11: maskedPend carries pending & enable and steerVec carries the routing vector. prioTable carries entry i in bits [7i+6:7i] as {bit 31, bits 5:0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcLevel | input | 40 | Level of each interrupt source |
| coreIdle | input | 1 | Core is in its idle state |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Combinational read data for addr |
| fiqOut | output | 1 | Fast interrupt request |
| irqOut | output | 1 | Normal interrupt request |
| wakeOut | output | 1 | Wake-from-idle indication |
| maskedPend | output | 40 | Enabled pending vector for the resolver |
| steerVec | output | 40 | Routing vector for the resolver |
| prioTable | output | 280 | Flattened priority table, 7 bits per entry |

## Verification
The hardest case to reach is a wake caused by a source that is pending but masked. It needs the core idle, the control bit cleared, and all enables for the active source lines off, all at the same time. It must also be told apart from an ordinary wake caused by an enabled source. The stimulus sets up that state on purpose: it writes the enable registers to zero, drives source levels, raises coreIdle, and then flips the control bit both ways while the model tracks every cycle. A long pseudo-random phase follows. It mixes writes to bank 1 registers carrying high data bits, writes to pending views and unmapped offsets, and changing source levels.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 6;
  typedef logic [ADDR_W-1:0] addr_t;

  // Register byte offsets (bank 0, then bank 1)
  localparam addr_t OFF_IRQP    = 8'h00;
  localparam addr_t OFF_MASK    = 8'h04;
  localparam addr_t OFF_STEER   = 8'h08;
  localparam addr_t OFF_FIQP    = 8'h0C;
  localparam addr_t OFF_RAW     = 8'h10;
  localparam addr_t OFF_CTRL    = 8'h14;
  localparam addr_t OFF_PRIO_LO = 8'h1C;
  localparam addr_t OFF_IRQP2   = 8'h9C;
  localparam addr_t OFF_MASK2   = 8'hA0;
  localparam addr_t OFF_STEER2  = 8'hA4;
  localparam addr_t OFF_FIQP2   = 8'hA8;
  localparam addr_t OFF_RAW2    = 8'hAC;
  localparam addr_t OFF_PRIO_HI = 8'hB0;

  typedef enum logic [2:0] {
    RD_NONE, RD_IRQP, RD_FIQP, RD_RAW, RD_MASK, RD_STEER, RD_CTRL, RD_PRIO
  } rdSel_e;

  typedef struct packed {
    logic             wrMask;
    logic             wrSteer;
    logic             wrCtrl;
    logic             wrPrio;
    logic             bankHi;
    logic [IDX_W-1:0] prioIdx;
    rdSel_e           rdSel;
  } intcStrb_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int DATA_W  = 32
) (
  input  logic      wrEn,
  input  addr_t     addr,
  output intcStrb_t strb
);
  localparam int    HI_CNT  = NUM_SRC - DATA_W;
  localparam addr_t LO_LAST = OFF_PRIO_LO + addr_t'(4 * (DATA_W - 1));
  localparam addr_t HI_LAST = OFF_PRIO_HI + addr_t'(4 * (HI_CNT - 1));

  addr_t offLo;
  addr_t offHi;
  logic  aligned;
  logic  inLo;
  logic  inHi;

  assign offLo   = addr - OFF_PRIO_LO;
  assign offHi   = addr - OFF_PRIO_HI;
  assign aligned = (addr[1:0] == 2'b00);
  assign inLo    = aligned && (addr >= OFF_PRIO_LO) && (addr <= LO_LAST);
  assign inHi    = aligned && (addr >= OFF_PRIO_HI) && (addr <= HI_LAST);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    case (addr)
      OFF_IRQP:   strb.rdSel = RD_IRQP;
      OFF_FIQP:   strb.rdSel = RD_FIQP;
      OFF_RAW:    strb.rdSel = RD_RAW;
      OFF_CTRL: begin
        strb.rdSel  = RD_CTRL;
        strb.wrCtrl = wrEn;
      end
      OFF_MASK: begin
        strb.rdSel  = RD_MASK;
        strb.wrMask = wrEn;
      end
      OFF_STEER: begin
        strb.rdSel   = RD_STEER;
        strb.wrSteer = wrEn;
      end
      OFF_IRQP2: begin
        strb.rdSel  = RD_IRQP;
        strb.bankHi = 1'b1;
      end
      OFF_FIQP2: begin
        strb.rdSel  = RD_FIQP;
        strb.bankHi = 1'b1;
      end
      OFF_RAW2: begin
        strb.rdSel  = RD_RAW;
        strb.bankHi = 1'b1;
      end
      OFF_MASK2: begin
        strb.rdSel  = RD_MASK;
        strb.bankHi = 1'b1;
        strb.wrMask = wrEn;
      end
      OFF_STEER2: begin
        strb.rdSel   = RD_STEER;
        strb.bankHi  = 1'b1;
        strb.wrSteer = wrEn;
      end
      default: begin
        if (inLo) begin
          strb.rdSel   = RD_PRIO;
          strb.wrPrio  = wrEn;
          strb.prioIdx = offLo[IDX_W+1:2];
        end else if (inHi) begin
          strb.rdSel   = RD_PRIO;
          strb.wrPrio  = wrEn;
          strb.prioIdx = IDX_W'(DATA_W) + offHi[IDX_W+1:2];
        end
      end
    endcase
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        srcLevel,
  input  logic                      coreIdle,
  input  logic [DATA_W-1:0]         wrData,
  input  intcStrb_t                 strb,
  output logic [DATA_W-1:0]         rdData,
  output logic                      fiqOut,
  output logic                      irqOut,
  output logic                      wakeOut,
  output logic [NUM_SRC-1:0]        maskedPend,
  output logic [NUM_SRC-1:0]        steerVec,
  output logic [NUM_SRC*PRIO_W-1:0] prioTable
);
  localparam int HI_CNT = NUM_SRC - DATA_W;
  localparam int ID_W   = PRIO_W - 1;

  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] steerQ;
  logic               ctrlQ;
  logic [NUM_SRC-1:0] enPend;
  logic [NUM_SRC-1:0] idleOverride;
  logic [PRIO_W-1:0]  prioArr [NUM_SRC];
  logic [PRIO_W-1:0]  prioSel;

  function automatic logic [DATA_W-1:0] bankSlice(input logic [NUM_SRC-1:0] vec,
                                                  input logic hi);
    logic [DATA_W-1:0] r;
    r = '0;
    if (hi) r[HI_CNT-1:0] = vec[NUM_SRC-1:DATA_W];
    else    r             = vec[DATA_W-1:0];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= srcLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      steerQ <= '0;
      ctrlQ  <= 1'b1;
    end else begin
      if (strb.wrMask) begin
        if (strb.bankHi) maskQ[NUM_SRC-1:DATA_W] <= wrData[HI_CNT-1:0];
        else             maskQ[DATA_W-1:0]       <= wrData;
      end
      if (strb.wrSteer) begin
        if (strb.bankHi) steerQ[NUM_SRC-1:DATA_W] <= wrData[HI_CNT-1:0];
        else             steerQ[DATA_W-1:0]       <= wrData;
      end
      if (strb.wrCtrl) ctrlQ <= wrData[0];
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    logic [PRIO_W-1:0] entQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) entQ <= '0;
      else if (strb.wrPrio && (strb.prioIdx == IDX_W'(i)))
        entQ <= {wrData[DATA_W-1], wrData[ID_W-1:0]};
    end
    assign prioArr[i]                    = entQ;
    assign prioTable[i*PRIO_W +: PRIO_W] = entQ;
  end

  assign enPend       = pendQ & maskQ;
  assign idleOverride = ctrlQ ? '0 : '1;
  assign fiqOut       = |(enPend & steerQ);
  assign irqOut       = |(enPend & ~steerQ);
  assign wakeOut      = coreIdle & (|(pendQ & (maskQ | idleOverride)));
  assign maskedPend   = enPend;
  assign steerVec     = steerQ;
  assign prioSel      = prioArr[strb.prioIdx];

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      RD_IRQP:  rdData = bankSlice(enPend & ~steerQ, strb.bankHi);
      RD_FIQP:  rdData = bankSlice(enPend & steerQ, strb.bankHi);
      RD_RAW:   rdData = bankSlice(pendQ, strb.bankHi);
      RD_MASK:  rdData = bankSlice(maskQ, strb.bankHi);
      RD_STEER: rdData = bankSlice(steerQ, strb.bankHi);
      RD_CTRL:  rdData[0] = ctrlQ;
      RD_PRIO: begin
        rdData[DATA_W-1]  = prioSel[PRIO_W-1];
        rdData[ID_W-1:0]  = prioSel[ID_W-1:0];
      end
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        srcLevel,
  input  logic                      coreIdle,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wrData,
  output logic [DATA_W-1:0]         rdData,
  output logic                      fiqOut,
  output logic                      irqOut,
  output logic                      wakeOut,
  output logic [NUM_SRC-1:0]        maskedPend,
  output logic [NUM_SRC-1:0]        steerVec,
  output logic [NUM_SRC*PRIO_W-1:0] prioTable
);
  intcStrb_t strb;

  intc_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .srcLevel   (srcLevel),
    .coreIdle   (coreIdle),
    .wrData     (wrData),
    .strb       (strb),
    .rdData     (rdData),
    .fiqOut     (fiqOut),
    .irqOut     (irqOut),
    .wakeOut    (wakeOut),
    .maskedPend (maskedPend),
    .steerVec   (steerVec),
    .prioTable  (prioTable)
  );
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 7
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_SRC-1:0]        srcLevel,
  input logic                      coreIdle,
  input logic                      wrEn,
  input logic [ADDR_W-1:0]         addr,
  input logic [DATA_W-1:0]         wrData,
  input logic [DATA_W-1:0]         rdData,
  input logic                      fiqOut,
  input logic                      irqOut,
  input logic                      wakeOut,
  input logic [NUM_SRC-1:0]        maskedPend,
  input logic [NUM_SRC-1:0]        steerVec,
  input logic [NUM_SRC*PRIO_W-1:0] prioTable
);
  // R3
  pend_follows_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((maskedPend & ~$past(srcLevel)) == '0));

  // R5
  fiq_needs_fast_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> ((maskedPend & steerVec) != '0));

  // R5
  irq_needs_normal_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((maskedPend & ~steerVec) != '0));

  // R7
  no_wake_when_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !coreIdle |-> !wakeOut);

  // R7
  wake_on_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreIdle && (fiqOut || irqOut)) |-> wakeOut);

  // R9
  prio_field_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_PRIO_LO) |=>
      (prioTable[PRIO_W-1:0] == {$past(wrData[DATA_W-1]), $past(wrData[PRIO_W-2:0])}));

  // R10
  pend_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == OFF_IRQP || addr == OFF_FIQP || addr == OFF_RAW ||
              addr == OFF_IRQP2 || addr == OFF_FIQP2 || addr == OFF_RAW2))
      |=> ($stable(steerVec) && $stable(prioTable)));

  // R10
  hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 8'h18 || addr[1:0] != 2'b00) |-> (rdData == '0));
endmodule

bind dual_bank_intc intc_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/dual_bank_intc_tb.sv
module dual_bank_intc_tb;
  localparam int NS = 40;
  localparam int PW = 7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcLevel = '0;
  logic          coreIdle = 1'b0;
  logic          wrEn = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic          fiqOut, irqOut, wakeOut;
  logic [NS-1:0] maskedPend, steerVec;
  logic [NS*PW-1:0] prioTable;

  always #10 clk = ~clk;

  dual_bank_intc u_dut (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .coreIdle(coreIdle),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .fiqOut(fiqOut), .irqOut(irqOut), .wakeOut(wakeOut),
    .maskedPend(maskedPend), .steerVec(steerVec), .prioTable(prioTable)
  );

  // behavioural reference state
  logic [NS-1:0] mPend, mMask, mSteer;
  logic          mCtrl;
  logic [PW-1:0] mPrio [NS];
  int            checks = 0;
  int            errors = 0;
  string         tag = "R2";
  bit            done = 0;
  logic [31:0]   rng = 32'h1234_5678;

  function automatic logic [31:0] bank(input logic [NS-1:0] v, input bit hi);
    logic [31:0] r;
    r = '0;
    if (hi) r[7:0] = v[39:32];
    else    r      = v[31:0];
    return r;
  endfunction

  function automatic int prioIndex(input logic [7:0] a);
    if (a[1:0] != 2'b00) return -1;
    if (a >= 8'h1C && a <= 8'h98) return (int'(a) - 28) / 4;
    if (a >= 8'hB0 && a <= 8'hCC) return 32 + (int'(a) - 176) / 4;
    return -1;
  endfunction

  function automatic logic [31:0] mRead(input logic [7:0] a);
    logic [NS-1:0] en;
    int idx;
    en = mPend & mMask;
    case (a)
      8'h00: return bank(en & ~mSteer, 0);
      8'h9C: return bank(en & ~mSteer, 1);
      8'h0C: return bank(en & mSteer, 0);
      8'hA8: return bank(en & mSteer, 1);
      8'h10: return bank(mPend, 0);
      8'hAC: return bank(mPend, 1);
      8'h04: return bank(mMask, 0);
      8'hA0: return bank(mMask, 1);
      8'h08: return bank(mSteer, 0);
      8'hA4: return bank(mSteer, 1);
      8'h14: return {31'b0, mCtrl};
      default: begin
        idx = prioIndex(a);
        if (idx >= 0) return {mPrio[idx][6], 25'b0, mPrio[idx][5:0]};
        return 32'h0;
      end
    endcase
  endfunction

  task automatic chk(input string t, input string what,
                     input logic [319:0] act, input logic [319:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [NS*PW-1:0] flat;
    logic [NS-1:0] en;
    if (!rstN) return;
    for (int i = 0; i < NS; i++) flat[i*PW +: PW] = mPrio[i];
    en = mPend & mMask;
    chk(tag, "rdData", rdData, mRead(addr));
    chk("R5", "fiqOut", fiqOut, |(en & mSteer));
    chk("R5", "irqOut", irqOut, |(en & ~mSteer));
    chk("R7", "wakeOut", wakeOut,
        coreIdle & (|(mPend & (mMask | (mCtrl ? {NS{1'b0}} : {NS{1'b1}})))));
    chk("R11", "maskedPend", maskedPend, en);
    chk("R11", "steerVec", steerVec, mSteer);
    chk("R11", "prioTable", prioTable, flat);
  endtask

  task automatic modelEdge();
    int idx;
    if (!rstN) begin
      mPend = '0; mMask = '0; mSteer = '0; mCtrl = 1'b1;
      for (int i = 0; i < NS; i++) mPrio[i] = '0;
      return;
    end
    if (wrEn) begin
      case (addr)
        8'h04: mMask[31:0]   = wrData;
        8'hA0: mMask[39:32]  = wrData[7:0];
        8'h08: mSteer[31:0]  = wrData;
        8'hA4: mSteer[39:32] = wrData[7:0];
        8'h14: mCtrl         = wrData[0];
        default: begin
          idx = prioIndex(addr);
          if (idx >= 0) mPrio[idx] = {wrData[31], wrData[5:0]};
        end
      endcase
    end
    mPend = srcLevel;
  endtask

  task automatic cyc();
    @(negedge clk);
    compareAll();
    @(posedge clk);
    modelEdge();
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    cyc();
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    addr = a;
    cyc();
  endtask

  function automatic logic [31:0] nextRng(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] pick [24];
    pick = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
             8'h20, 8'h98, 8'h9C, 8'hA0, 8'hA4, 8'hA8, 8'hAC, 8'hB0,
             8'hB4, 8'hCC, 8'hD0, 8'h1D, 8'h06, 8'hFC, 8'h7C, 8'hC0};
    mPend = '0; mMask = '0; mSteer = '0; mCtrl = 1'b1;
    for (int i = 0; i < NS; i++) mPrio[i] = '0;

    // R2: reset state
    repeat (3) cyc();
    rstN = 1'b1;
    tag = "R2";
    rd(8'h04); rd(8'h08); rd(8'h10); rd(8'h14); rd(8'h1C); rd(8'hA0); rd(8'hCC);

    // R1 / R3: bank mapping and level following
    tag = "R1";
    srcLevel = 40'h01_0000_0001;
    rd(8'h10); rd(8'hAC);
    srcLevel = 40'h80_8000_0000;
    rd(8'h10); rd(8'hAC); rd(8'h10);
    tag = "R3";
    srcLevel = '0;
    rd(8'hAC); rd(8'hAC); rd(8'h10);

    // R6: enable and routing registers, bank 1 keeps low byte only
    tag = "R6";
    wr(8'h04, 32'hFFFF_0F0F); wr(8'hA0, 32'hFFFF_FFA5);
    rd(8'h04); rd(8'hA0);
    wr(8'h08, 32'h0F0F_00FF); wr(8'hA4, 32'h1234_563C);
    rd(8'h08); rd(8'hA4);

    // R4: filtered views
    tag = "R4";
    srcLevel = 40'hA5_F0F0_3C3C;
    rd(8'h00); rd(8'h0C); rd(8'h9C); rd(8'hA8); rd(8'h10);

    // R5: routing extremes
    tag = "R5";
    wr(8'h08, 32'h0); wr(8'hA4, 32'h0); rd(8'h00);
    wr(8'h08, 32'hFFFF_FFFF); wr(8'hA4, 32'hFF); rd(8'h0C);
    wr(8'h04, 32'h0); wr(8'hA0, 32'h0); rd(8'h0C);

    // R7 / R8: wake from idle with masked sources
    tag = "R8";
    coreIdle = 1'b1;
    rd(8'h14);
    wr(8'h14, 32'h0); rd(8'h14);
    tag = "R7";
    rd(8'h10);
    srcLevel = 40'h80_0000_0000; rd(8'hAC);
    srcLevel = '0; rd(8'hAC); rd(8'hAC);
    srcLevel = 40'h00_0000_0100; rd(8'h14);
    tag = "R8";
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14);
    wr(8'h14, 32'hFFFF_FFFE); rd(8'h14);
    wr(8'h14, 32'h1);
    tag = "R7";
    wr(8'h04, 32'h0000_0100); rd(8'h00);
    coreIdle = 1'b0; rd(8'h00);

    // R9: priority table write and readback
    tag = "R9";
    for (int i = 0; i < NS; i++) begin
      logic [7:0] a;
      a = (i < 32) ? 8'(28 + 4*i) : 8'(176 + 4*(i-32));
      wr(a, 32'(i) * 32'h9E37_79B9 ^ 32'hC000_0000);
    end
    for (int i = 0; i < NS; i++) begin
      logic [7:0] a;
      a = (i < 32) ? 8'(28 + 4*i) : 8'(176 + 4*(i-32));
      rd(a);
    end

    // R10: unmapped and read-only offsets
    tag = "R10";
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF);
    wr(8'hD0, 32'hFFFF_FFFF); wr(8'h1D, 32'hFFFF_FFFF); wr(8'h9C, 32'hFFFF_FFFF);
    wr(8'hAC, 32'hFFFF_FFFF); wr(8'h06, 32'hFFFF_FFFF);
    rd(8'h18); rd(8'hD0); rd(8'h1D); rd(8'hFC); rd(8'h04); rd(8'h1C);

    // R11: mixed pseudo-random traffic
    tag = "R11";
    for (int n = 0; n < 600; n++) begin
      rng = nextRng(rng);
      srcLevel[31:0] = rng;
      rng = nextRng(rng);
      srcLevel[39:32] = rng[7:0];
      coreIdle = rng[8];
      addr = rng[9] ? rng[23:16] : pick[rng[14:10] % 24];
      rng = nextRng(rng);
      wrData = rng;
      wrEn = rng[3] & rng[7];
      cyc();
      wrEn = 1'b0;
    end

    done = 1;
    summary();
    $finish;
  end
endmodule